// File: doc/BRIEF.md
# Dual-Segment Modulation Sample Sequencer

The sequencer plays back an 8-bit amplitude waveform from one of two sample memories, called segment 0 and segment 1. Each segment has its own settings: a rate divider, a last-index value that sets the waveform length, and a repeat count. A divider sets how fast the read index moves through the samples. The sample at the current index, the active segment and the index itself are presented on the outputs every cycle.

Software writes 16-bit configuration words over a simple write port. Sample memory words are loaded over a second write port. A write to the request register asks for a change to a named segment. The change waits for one of five trigger conditions: the end of the current pass, a system-time deadline, a rising edge on a chosen general-purpose input, a rising edge on an external trigger pin, or the next divider tick. When the change happens, the new segment starts from index 0 with its own repeat counting.

Configuration map (word address on `cfg_addr`): segment s uses address 4*s+0 for its divider, 4*s+1 for its last index and 4*s+2 for its repeat count. Address 8 holds the trigger mode in bits 2:0. A write to address 9 requests the segment named in bit 0. Addresses 12 to 15 hold the 64-bit trigger value, starting with its least significant 16 bits.

Top module: `mod_sequencer`

## Requirements
- R1: After a clock edge with `rst_n` low, `seg_o` is 0 and `idx_o` is 0. After reset, both segments have divider 0 and last index 0, both repeat counts are 0xFFFF, the trigger mode is 0 and no request is pending.
- R2: The index runs from 0 up to the active segment's last-index value L and then returns to 0. A pass therefore has L+1 samples.
- R3: Sample memory word w holds two samples. Index 2w is in bits 7:0 and index 2w+1 is in bits 15:8. `sample_o` is the byte for (`seg_o`, `idx_o`) in the same cycle.
- R4: With divider value D, the index moves once every D+1 cycles. The divider counter restarts after each tick. A counter already at or above a newly written D also ticks.
- R5: A repeat count of 0xFFFF loops without end. A value v stops the index at the last sample when a pass ends with at least v passes already completed since the segment started. That gives v+1 passes. The index then holds until a switch.
- R6: Mode 0 (end-of-pass) switches on a tick at which the index is at or past the last-index value. This includes a segment that has stopped.
- R7: Mode 4 (immediate) switches on the first divider tick after the request. Reserved modes 5 to 7 act the same way.
- R8: Mode 1 (time) switches on the first tick at which `sys_time` is greater than or equal to the 64-bit trigger value.
- R9: Mode 2 (input edge) watches `gpio_in[k]`, where k is bits 1:0 of the trigger value. A rising edge seen while a request is pending arms the switch, which happens on a later tick. Edges on the other inputs have no effect.
- R10: Mode 3 (external) works like R9 but watches `ext_trig`. In this mode, edges on `gpio_in` have no effect.
- R11: On a switch, the active segment becomes the requested one, the index and the pass count go to 0, and the pending request clears. A new request made while one is pending replaces it and clears any armed edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| ram_we | input | 1 | Sample memory write strobe |
| ram_seg | input | 1 | Segment whose memory is written |
| ram_addr | input | 8 | Sample memory word address |
| ram_wdata | input | 16 | Two packed samples |
| sys_time | input | 64 | System time in nanoseconds |
| gpio_in | input | 4 | General-purpose trigger inputs |
| ext_trig | input | 1 | External trigger input |
| sample_o | output | 8 | Current sample |
| seg_o | output | 1 | Active segment |
| idx_o | output | 9 | Current sample index |

## Verification
A configuration write, request or trigger input present before a rising edge is seen in the state after that edge. The earliest resulting change to `seg_o` or `idx_o` is one edge later: the tick that uses a setting, or the switch that answers a request, lands on the edge after the write. An armed input edge acts only from the edge after that. `sample_o` follows the index in the same cycle, with no added delay. The bench drives and samples on the falling edge. It keeps a cycle-accurate model that advances on each rising edge from the same inputs, and compares the outputs against it every cycle. Directed checks wait for a named output event (an index value, a segment change) rather than counting fixed delays.

// File: rtl/mseq_pkg.sv
// Package: shared constants and types for the modulation sequencer.
// Assumes a 16-bit configuration word and two segments.
package mseq_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned NSEG   = 2;
    localparam int unsigned TGT_W  = 64;

    // trigger mode codes (reserved codes behave as immediate)
    localparam logic [2:0] TM_SYNC = 3'd0;
    localparam logic [2:0] TM_TIME = 3'd1;
    localparam logic [2:0] TM_GPIO = 3'd2;
    localparam logic [2:0] TM_EXT  = 3'd3;
    localparam logic [2:0] TM_IMM  = 3'd4;

    // configuration addresses
    localparam logic [3:0] A_MODE = 4'd8;
    localparam logic [3:0] A_REQ  = 4'd9;

    localparam logic [DATA_W-1:0] REP_FOREVER = '1;

    typedef struct packed {
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] last;
        logic [DATA_W-1:0] rep;
    } seg_cfg_t;
endpackage

// File: rtl/mseq_regs.sv
// Module: configuration register file. Holds per-segment settings, the
// trigger mode and the 64-bit trigger value; decodes request writes.
// Assumes single-cycle writes with no read-back.
module mseq_regs
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output seg_cfg_t          cfg_o [NSEG],
    output logic [2:0]        mode_o,
    output logic [TGT_W-1:0]  target_o,
    output logic              req_wr_o,
    output logic              req_seg_o
);
    localparam int unsigned TGT_WORDS = TGT_W / DATA_W;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        // purpose: store divider, last index and repeat count of segment s
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[s] <= '{div: '0, last: '0, rep: REP_FOREVER};
            end else if (we && !addr[3] && (addr[2] == s[0])) begin
                case (addr[1:0])
                    2'd0:    cfg_o[s].div  <= wdata;
                    2'd1:    cfg_o[s].last <= wdata;
                    2'd2:    cfg_o[s].rep  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar w = 0; w < TGT_WORDS; w++) begin : g_tgt
        // purpose: store one 16-bit slice of the trigger value
        always_ff @(posedge clk) begin
            if (!rst_n)
                target_o[w*DATA_W +: DATA_W] <= '0;
            else if (we && addr[3:2] == 2'b11 && addr[1:0] == w[1:0])
                target_o[w*DATA_W +: DATA_W] <= wdata;
        end
    end

    // purpose: store the trigger mode
    always_ff @(posedge clk) begin
        if (!rst_n)                     mode_o <= TM_SYNC;
        else if (we && addr == A_MODE)  mode_o <= wdata[2:0];
    end

    // purpose: turn a write to the request address into a one-cycle strobe
    always_comb begin
        req_wr_o  = we && (addr == A_REQ);
        req_seg_o = wdata[0];
    end
endmodule

// File: rtl/mseq_divider.sv
// Module: sample-rate divider. Produces one tick every div_val+1 cycles.
// Assumes div_val may change at any time; a counter at or above it ticks.
module mseq_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // purpose: tick when the count has reached the division value
    always_comb tick = (cnt_q >= div_val);

    // purpose: count cycles and restart after each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    a_r4_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/mseq_sample_ram.sv
// Module: one segment's sample memory, two 8-bit samples per 16-bit word.
// Assumes an asynchronous read and a write port that does not reset.
module mseq_sample_ram #(
    parameter int unsigned WORDS = 256
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [15:0]          wdata,
    input  logic [$clog2(WORDS):0]   rd_idx,
    output logic [7:0]           rd_byte
);
    localparam int unsigned AW = $clog2(WORDS);

    logic [15:0] mem [WORDS];
    logic [15:0] word;

    // purpose: write one packed word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // purpose: pick the byte that the index parity selects
    always_comb begin
        word    = mem[rd_idx[AW:1]];
        rd_byte = rd_idx[0] ? word[15:8] : word[7:0];
    end
endmodule

// File: rtl/mseq_trigger.sv
// Module: segment-change trigger. Holds a pending request and decides, per
// mode, the divider tick on which the change happens (fire).
// Assumes tick and at_last come from the playback state of the same cycle.
module mseq_trigger
    import mseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic [TGT_W-1:0] target,
    input  logic [TGT_W-1:0] sys_time,
    input  logic [3:0]       gpio_in,
    input  logic             ext_trig,
    input  logic             req_wr,
    input  logic             req_seg,
    input  logic             tick,
    input  logic             at_last,
    output logic             fire,
    output logic             pend_seg
);
    logic pend_q, seen_q, src_prev_q;
    logic src, rise, edge_mode, cond;

    // purpose: select the watched input and detect its rising edge
    always_comb begin
        src       = (mode == TM_GPIO) ? gpio_in[target[1:0]] : ext_trig;
        rise      = src && !src_prev_q;
        edge_mode = (mode == TM_GPIO) || (mode == TM_EXT);
    end

    // purpose: evaluate the change condition for the current mode
    always_comb begin
        case (mode)
            TM_SYNC:        cond = at_last;
            TM_TIME:        cond = (sys_time >= target);
            TM_GPIO,TM_EXT: cond = seen_q;
            default:        cond = 1'b1;
        endcase
        fire = pend_q && tick && cond;
    end

    // purpose: track pending request, requested segment and armed edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_seg   <= 1'b0;
            seen_q     <= 1'b0;
            src_prev_q <= 1'b0;
        end else begin
            src_prev_q <= src;
            if (req_wr) begin
                pend_q   <= 1'b1;
                pend_seg <= req_seg;
                seen_q   <= 1'b0;
            end else if (fire) begin
                pend_q <= 1'b0;
                seen_q <= 1'b0;
            end else if (pend_q && rise && edge_mode) begin
                seen_q <= 1'b1;
            end
        end
    end

    a_r9_edge_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen_q) |-> $past(pend_q));
    a_r11_fire_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_wr) |=> !pend_q);
endmodule

// File: rtl/mod_sequencer.sv
// Module: top of the dual-segment modulation sequencer. Steps the read index
// on divider ticks, counts passes, stops after finite repeats and applies
// segment changes chosen by the trigger.
// Assumes the last-index value fits the index range of the sample memory.
module mod_sequencer
    import mseq_pkg::*;
#(
    parameter int unsigned WORDS = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [3:0]               cfg_addr,
    input  logic [15:0]              cfg_wdata,
    input  logic                     ram_we,
    input  logic                     ram_seg,
    input  logic [$clog2(WORDS)-1:0] ram_addr,
    input  logic [15:0]              ram_wdata,
    input  logic [63:0]              sys_time,
    input  logic [3:0]               gpio_in,
    input  logic                     ext_trig,
    output logic [7:0]               sample_o,
    output logic                     seg_o,
    output logic [$clog2(WORDS):0]   idx_o
);
    localparam int unsigned WORD_AW = $clog2(WORDS);
    localparam int unsigned IDX_W   = WORD_AW + 1;

    seg_cfg_t          cfg [NSEG];
    seg_cfg_t          cur;
    logic [2:0]        mode;
    logic [TGT_W-1:0]  target;
    logic              req_wr, req_seg, tick, fire, pend_seg, at_last;
    logic              seg_q, stopped_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] loop_q;
    logic [7:0]        rd_b [NSEG];

    mseq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg_o(cfg), .mode_o(mode), .target_o(target),
        .req_wr_o(req_wr), .req_seg_o(req_seg)
    );

    // purpose: settings of the active segment and end-of-pass detection
    always_comb begin
        cur     = cfg[seg_q];
        at_last = ({{(DATA_W-IDX_W){1'b0}}, idx_q} >= cur.last);
    end

    mseq_divider #(.DIV_W(DATA_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_val(cur.div), .tick(tick)
    );

    mseq_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .mode(mode), .target(target),
        .sys_time(sys_time), .gpio_in(gpio_in), .ext_trig(ext_trig),
        .req_wr(req_wr), .req_seg(req_seg), .tick(tick), .at_last(at_last),
        .fire(fire), .pend_seg(pend_seg)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_ram
        mseq_sample_ram #(.WORDS(WORDS)) u_ram (
            .clk(clk), .we(ram_we && (ram_seg == s[0])), .waddr(ram_addr),
            .wdata(ram_wdata), .rd_idx(idx_q), .rd_byte(rd_b[s])
        );
    end

    // purpose: step the index, count passes, stop or change segment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q     <= 1'b0;
            idx_q     <= '0;
            loop_q    <= '0;
            stopped_q <= 1'b0;
        end else if (fire) begin
            seg_q     <= pend_seg;
            idx_q     <= '0;
            loop_q    <= '0;
            stopped_q <= 1'b0;
        end else if (tick && !stopped_q) begin
            if (at_last) begin
                if (cur.rep != REP_FOREVER && loop_q >= cur.rep) begin
                    stopped_q <= 1'b1;
                end else begin
                    idx_q  <= '0;
                    loop_q <= loop_q + 1'b1;
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // purpose: drive the outputs from the playback state
    always_comb begin
        seg_o    = seg_q;
        idx_o    = idx_q;
        sample_o = rd_b[seg_q];
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (seg_q == 1'b0 && idx_q == '0));
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(idx_q) && $stable(seg_q)));
    a_r5_stopped_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_q && !fire) |=> ($stable(idx_q) && $stable(seg_q)));
    a_r11_switch_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q != $past(seg_q)) |-> (idx_q == '0));
endmodule

// File: tb/tb_mod_sequencer.sv
module tb_mod_sequencer;
    localparam int WORDS = 256;
    localparam int AW    = $clog2(WORDS);
    localparam int IW    = AW + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0; logic [3:0] cfg_addr = '0; logic [15:0] cfg_wdata = '0;
    logic ram_we = 1'b0, ram_seg = 1'b0; logic [AW-1:0] ram_addr = '0;
    logic [15:0] ram_wdata = '0;
    logic [63:0] sys_time = 64'd1000;
    logic [3:0] gpio_in = '0; logic ext_trig = 1'b0;
    logic [7:0] sample_o; logic seg_o; logic [IW-1:0] idx_o;

    mod_sequencer #(.WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ram_we(ram_we), .ram_seg(ram_seg),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .sys_time(sys_time),
        .gpio_in(gpio_in), .ext_trig(ext_trig), .sample_o(sample_o),
        .seg_o(seg_o), .idx_o(idx_o)
    );

    always #2 clk = ~clk;
    always @(negedge clk) sys_time <= sys_time + 64'd4;

    int checks = 0, errors = 0;
    bit done = 0, cmp_on = 0, mem_ok = 0;
    string tag = "R1";

    task automatic chk(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    // ---------------- reference model, built from the requirements ----------
    logic [15:0] m_div [2], m_last [2], m_rep [2];
    logic [15:0] m_mem [2][WORDS];
    logic [2:0]  m_mode; logic [63:0] m_tgt;
    logic m_seg, m_stop, m_pend, m_pseg, m_seen, m_prev;
    logic [IW-1:0] m_idx; logic [15:0] m_loop, m_cnt;

    function automatic logic [7:0] exp_byte(logic s, logic [IW-1:0] i);
        logic [15:0] w = m_mem[s][i[IW-1:1]];
        return i[0] ? w[15:8] : w[7:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin m_div[s] = 0; m_last[s] = 0; m_rep[s] = 16'hFFFF; end
            m_mode = 0; m_tgt = 0; m_seg = 0; m_stop = 0; m_pend = 0; m_pseg = 0;
            m_seen = 0; m_prev = 0; m_idx = 0; m_loop = 0; m_cnt = 0;
        end else begin
            logic tk, lst, src, rise, cnd, fr;
            tk   = m_cnt >= m_div[m_seg];
            lst  = {{(16-IW){1'b0}}, m_idx} >= m_last[m_seg];
            src  = (m_mode == 3'd2) ? gpio_in[m_tgt[1:0]] : ext_trig;
            rise = src && !m_prev;
            case (m_mode)
                3'd0: cnd = lst;
                3'd1: cnd = sys_time >= m_tgt;
                3'd2, 3'd3: cnd = m_seen;
                default: cnd = 1'b1;
            endcase
            fr = m_pend && tk && cnd;
            if (fr) begin
                m_seg = m_pseg; m_idx = 0; m_loop = 0; m_stop = 0;
            end else if (tk && !m_stop) begin
                if (lst) begin
                    if (m_rep[m_seg] != 16'hFFFF && m_loop >= m_rep[m_seg]) m_stop = 1;
                    else begin m_idx = 0; m_loop = m_loop + 1; end
                end else m_idx = m_idx + 1;
            end
            m_cnt = tk ? 16'd0 : m_cnt + 16'd1;
            m_prev = src;
            if (cfg_we && cfg_addr == 4'd9) begin
                m_pend = 1; m_pseg = cfg_wdata[0]; m_seen = 0;
            end else if (fr) begin
                m_pend = 0; m_seen = 0;
            end else if (m_pend && rise && (m_mode == 3'd2 || m_mode == 3'd3)) m_seen = 1;
            if (cfg_we) begin
                if (!cfg_addr[3]) begin
                    case (cfg_addr[1:0])
                        2'd0: m_div[cfg_addr[2]]  = cfg_wdata;
                        2'd1: m_last[cfg_addr[2]] = cfg_wdata;
                        2'd2: m_rep[cfg_addr[2]]  = cfg_wdata;
                        default: ;
                    endcase
                end else if (cfg_addr == 4'd8) m_mode = cfg_wdata[2:0];
                else if (cfg_addr[3:2] == 2'b11) m_tgt[cfg_addr[1:0]*16 +: 16] = cfg_wdata;
            end
            if (ram_we) m_mem[ram_seg][ram_addr] = ram_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) if (cmp_on) begin
        chk(tag, "seg", seg_o, m_seg);
        chk(tag, "idx", idx_o, m_idx);
        if (mem_ok) chk(tag, "sample", sample_o, exp_byte(m_seg, m_idx));
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg_wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask
    task automatic ram_wr(logic s, logic [AW-1:0] a, logic [15:0] d);
        @(negedge clk); ram_we = 1; ram_seg = s; ram_addr = a; ram_wdata = d;
        @(negedge clk); ram_we = 0;
    endtask
    task automatic set_tgt(logic [63:0] v);
        for (int w = 0; w < 4; w++) cfg_wr(4'(12 + w), v[w*16 +: 16]);
    endtask
    task automatic idle(int n); repeat (n) @(negedge clk); endtask
    task automatic wait_seg(logic s, int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim && !ok; i++) begin @(negedge clk); ok = (seg_o == s); end
    endtask
    task automatic wait_idx(logic [IW-1:0] v, int lim);
        for (int i = 0; i < lim && idx_o != v; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok; int gap; logic [IW-1:0] prev; logic [63:0] t0;
        void'($urandom(32'd1234));
        idle(3);
        @(negedge clk);
        chk("R1", "reset seg", seg_o, 0); chk("R1", "reset idx", idx_o, 0);
        rst_n = 1; cmp_on = 1;
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < WORDS; a++) ram_wr(s[0], AW'(a), 16'($urandom));
        ram_wr(0, 0, 16'h1234); ram_wr(0, 1, 16'h5678);
        mem_ok = 1;

        // R3 packing and R2 wrap on segment 0
        tag = "R3";
        cfg_wr(4'd1, 16'd2);
        wait_idx(0, 20); chk("R3", "even byte", sample_o, 8'h34);
        wait_idx(1, 20); chk("R3", "odd byte", sample_o, 8'h12);
        wait_idx(2, 20); chk("R3", "word1 low", sample_o, 8'h78);
        tag = "R2";
        begin
            int mx = 0; bit wrapped = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (idx_o > mx) mx = idx_o;
                if (i > 0 && idx_o == 0 && prev == 2) wrapped = 1;
                prev = idx_o;
            end
            chk("R2", "max index", mx, 2); chk("R2", "wrap seen", wrapped, 1);
        end

        // R4 divider spacing
        tag = "R4";
        cfg_wr(4'd0, 16'd3);
        prev = idx_o; for (int i = 0; i < 20 && idx_o == prev; i++) @(negedge clk);
        prev = idx_o; gap = 0;
        for (int i = 0; i < 20 && idx_o == prev; i++) begin @(negedge clk); gap++; end
        chk("R4", "cycles per step", gap, 4);

        // R6 end-of-pass switch to segment 1
        tag = "R6";
        cfg_wr(4'd5, 16'd5); cfg_wr(4'd4, 16'd1);
        cfg_wr(4'd9, 16'd1);
        ok = 0;
        for (int i = 0; i < 100 && !ok; i++) begin prev = idx_o; @(negedge clk); ok = seg_o; end
        chk("R6", "switched", ok, 1); chk("R6", "new idx", idx_o, 0);
        chk("R6", "left at last", prev, 2);

        // R5 finite repeats, entered by an immediate switch (R7)
        tag = "R5";
        cfg_wr(4'd2, 16'd1); cfg_wr(4'd8, 16'd4); cfg_wr(4'd9, 16'd0);
        wait_seg(0, 20, ok); chk("R7", "immediate back to 0", ok, 1);
        idle(60); chk("R5", "held at last", idx_o, 2);
        idle(8);  chk("R5", "still held", idx_o, 2);

        // R7 immediate switch on the next tick (div 3)
        tag = "R7";
        cfg_wr(4'd4, 16'd9); cfg_wr(4'd9, 16'd1);
        wait_seg(1, 5, ok); chk("R7", "switch within one tick", ok, 1);

        // R8 time-based switch
        tag = "R8";
        cfg_wr(4'd8, 16'd1); t0 = sys_time + 64'd600; set_tgt(t0); cfg_wr(4'd9, 16'd0);
        idle(50); chk("R8", "early no switch", seg_o, 1);
        wait_seg(0, 200, ok); chk("R8", "switched", ok, 1);
        chk("R8", "time reached", sys_time >= t0, 1);

        // R9 input-edge switch on gpio_in[2]
        tag = "R9";
        cfg_wr(4'd8, 16'd2); set_tgt(64'd2); cfg_wr(4'd9, 16'd1);
        @(negedge clk); gpio_in = 4'b1010; idle(3); gpio_in = 0;
        idle(20); chk("R9", "other inputs ignored", seg_o, 0);
        gpio_in = 4'b0100; idle(2); gpio_in = 0;
        wait_seg(1, 20, ok); chk("R9", "selected edge switches", ok, 1);

        // R10 external trigger
        tag = "R10";
        cfg_wr(4'd8, 16'd3); cfg_wr(4'd9, 16'd0);
        @(negedge clk); gpio_in = 4'b1111; idle(3); gpio_in = 0;
        idle(30); chk("R10", "gpio ignored", seg_o, 1);
        ext_trig = 1; idle(2); ext_trig = 0;
        wait_seg(0, 30, ok); chk("R10", "ext switches", ok, 1);

        // R11 later request replaces a pending one
        tag = "R11";
        cfg_wr(4'd8, 16'd1); t0 = sys_time + 64'd400; set_tgt(t0);
        cfg_wr(4'd9, 16'd0); cfg_wr(4'd9, 16'd1);
        idle(20); chk("R11", "waiting", seg_o, 0);
        wait_seg(1, 200, ok); chk("R11", "latest request wins", ok, 1);

        // random mix, model compare every cycle
        tag = "R2,R4,R5,R6,R7,R8,R9,R10,R11";
        for (int it = 0; it < 1500; it++) begin
            int r = $urandom_range(0, 9);
            case (r)
                0: cfg_wr(4'($urandom_range(0, 1) * 4), 16'($urandom_range(0, 3)));
                1: cfg_wr(4'($urandom_range(0, 1) * 4 + 1), 16'($urandom_range(0, 20)));
                2: begin
                    int k = $urandom_range(0, 3);
                    cfg_wr(4'($urandom_range(0, 1) * 4 + 2), (k == 0) ? 16'hFFFF : 16'(k - 1));
                end
                3: cfg_wr(4'd8, 16'($urandom_range(0, 4)));
                4: set_tgt(sys_time + 64'($urandom_range(0, 200)));
                5: cfg_wr(4'd9, 16'($urandom_range(0, 1)));
                6: begin @(negedge clk); gpio_in = 4'($urandom); end
                7: begin @(negedge clk); ext_trig = 1'($urandom); end
                default: idle($urandom_range(1, 6));
            endcase
        end
        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule